// File: doc/BRIEF.md
# Search Window Register Array

This block keeps a square window of reference pixels in registers for a motion-estimation engine. The window sits inside a larger square search area. A block-matching array downstream reads every window pixel in parallel. The window moves through the search area in a serpentine path. It sweeps down one column strip, shifts one pixel sideways, sweeps back up, shifts sideways again, and so on. Each search-area column lives in its own line memory, and each line memory returns one byte per clock.

A vertical step needs one new byte from each of the window's columns, so it never stalls. A sideways step needs a whole new column, and all of that column comes from one line memory. To handle this, the block keeps a shadow column of registers beside the window's leading edge and fills it ahead of time, one byte per vertical step. The sideways step then swaps the shadow column in within one clock. The sideways step also uses the idle port of the following column to start filling the next shadow column. As a result, when the search area is at least twice the window size less one, every full serpentine sweep ends with a shadow column that is already complete.

A start pulse gives the origin of the search. The block clears the array, preloads the first window row by row, and then raises a valid flag. After that it accepts step commands over a valid/ready handshake.

Top module: `swin_array`

## Requirements
- R1: After reset, win_valid and step_ready are low, win_x and win_y are 0, every lm_en bit is 0 and every win_pix byte is 0.
- R2: A start pulse clamps each origin coordinate to at most AREA-WIN. On the next cycle win_valid is low and win_pix is all zero. The window is then loaded one row per cycle (rows y..y+WIN-1), and win_valid rises WIN cycles after the start edge.
- R3: While win_valid is high, window pixel (row i, column j) is at win_pix[(i*WIN+j)*8 +: 8] and equals search-area pixel (win_y+i, win_x+j).
- R4: Direction code 2'b00 moves the window down (win_y+1), 2'b01 moves it up (win_y-1) and 2'b10 moves it sideways (win_x+1). Code 2'b11 is never accepted.
- R5: step_ready is high only while win_valid is high and start is low, and only when the move keeps the window inside the search area.
- R6: An accepted step (step_valid and step_ready high at a clock edge) updates win_pix, win_x and win_y at that same edge.
- R7: A step that is not accepted, and any idle cycle, leaves win_pix, win_x and win_y unchanged.
- R8: All line memories share one row address, lm_row, and each enabled memory supplies one byte in that cycle. On a down step the enabled memories are win_x..win_x+WIN, with row win_y+WIN. On an up step they are the same memories, with row win_y-1. On a sideways step only memory win_x+WIN+1 is enabled, with row win_y when win_y equals AREA-WIN and row win_y+WIN-1 otherwise. On an idle cycle no memory is enabled.
- R9: A sideways step is accepted only when the shadow column holds all WIN rows of the window for column win_x+WIN. Preload rows and vertical steps add rows to the shadow column. Rows that leave the window drop out. A sideways step empties the shadow column and then adds the single row it read.
- R10: With AREA = 2*WIN-1, the sideways step at the end of every complete sweep is accepted in the first cycle it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search at the given origin |
| org_x | input | AW | Origin column (AW = clog2(AREA)) |
| org_y | input | AW | Origin row |
| step_valid | input | 1 | Step request |
| step_dir | input | 2 | Step direction code |
| step_ready | output | 1 | Step can be taken this cycle |
| lm_en | output | AREA | Read enable, one per line memory |
| lm_row | output | AW | Shared row address for the line memories |
| lm_data | input | AREA*8 | Read data, byte m from line memory m, valid in the same cycle |
| win_valid | output | 1 | Window contents are valid |
| win_x | output | AW | Current window column |
| win_y | output | AW | Current window row |
| win_pix | output | WIN*WIN*8 | Window pixels, row-major |

## Verification
The hardest situation to reach from the ports is a sideways step requested while the shadow column is only partly full. A serpentine scan that follows the rules never produces it. The stimulus gets there with a pseudo-random walk that mixes sideways requests right after other sideways steps, reversals in the middle of a sweep, reserved codes and restarts. For each request, a row-occupancy model in the bench predicts whether it is accepted. The bench also runs every origin of a small window through a complete serpentine scan, to show that turnarounds never stall.

// File: rtl/swin_pkg.sv
package swin_pkg;
  typedef enum logic [1:0] {
    STEP_DOWN = 2'b00,
    STEP_UP   = 2'b01,
    STEP_LAT  = 2'b10,
    STEP_RSV  = 2'b11
  } step_dir_e;
endpackage

// File: rtl/swin_ctrl.sv
module swin_ctrl import swin_pkg::*; #(
  parameter int WIN  = 16,
  parameter int AREA = 31,
  parameter int AW   = $clog2(AREA)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   org_x,
  input  logic [AW-1:0]   org_y,
  input  logic            step_valid,
  input  logic [1:0]      step_dir,
  input  logic            sh_full,
  output logic            step_ready,
  output logic            win_valid,
  output logic [AW-1:0]   win_x,
  output logic [AW-1:0]   win_y,
  output logic [AREA-1:0] lm_en,
  output logic [AW-1:0]   lm_row,
  output logic            op_clear,
  output logic            op_fill_bot,
  output logic            op_fill_top,
  output logic            op_lat,
  output logic            lat_at_bottom,
  output logic            col_ok,
  output logic            next_ok
);
  localparam int MAXPOS = AREA - WIN;
  localparam int CW     = $clog2(WIN);

  logic [AW-1:0] x_q, x_d, y_q, y_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          load_q, load_d, valid_q, valid_d;
  logic          legal, acc, go_down, go_up, go_lat, rd_vert, upd;
  int            row_i;

  // Move legality per direction
  always_comb begin
    case (step_dir)
      STEP_DOWN: legal = int'(y_q) < MAXPOS;
      STEP_UP:   legal = int'(y_q) > 0;
      STEP_LAT:  legal = (int'(x_q) < MAXPOS) && sh_full;
      default:   legal = 1'b0;
    endcase
  end

  assign step_ready = valid_q & ~start & legal;
  assign acc        = step_valid & step_ready;
  assign go_down    = acc && (step_dir == STEP_DOWN);
  assign go_up      = acc && (step_dir == STEP_UP);
  assign go_lat     = acc && (step_dir == STEP_LAT);
  assign rd_vert    = load_q | go_down | go_up;

  // Line-memory address and enables
  always_comb begin
    if (load_q)       row_i = int'(y_q) + int'(cnt_q);
    else if (go_down) row_i = int'(y_q) + WIN;
    else if (go_up)   row_i = int'(y_q) - 1;
    else if (go_lat)  row_i = (int'(y_q) == MAXPOS) ? int'(y_q) : int'(y_q) + WIN - 1;
    else              row_i = 0;
    lm_row = AW'(row_i);
    for (int m = 0; m < AREA; m++) begin
      lm_en[m] = (rd_vert && (m >= int'(x_q)) && (m <= int'(x_q) + WIN)) ||
                 (go_lat && (m == int'(x_q) + WIN + 1));
    end
  end

  assign op_clear      = start;
  assign op_fill_bot   = load_q | go_down;
  assign op_fill_top   = go_up;
  assign op_lat        = go_lat;
  assign lat_at_bottom = (int'(y_q) == MAXPOS);
  assign col_ok        = (int'(x_q) + WIN) < AREA;
  assign next_ok       = (int'(x_q) + WIN + 1) < AREA;

  // Next state
  always_comb begin
    x_d     = x_q;
    y_d     = y_q;
    cnt_d   = cnt_q;
    load_d  = load_q;
    valid_d = valid_q;
    if (start) begin
      x_d     = (int'(org_x) > MAXPOS) ? AW'(MAXPOS) : org_x;
      y_d     = (int'(org_y) > MAXPOS) ? AW'(MAXPOS) : org_y;
      cnt_d   = '0;
      load_d  = 1'b1;
      valid_d = 1'b0;
    end else if (load_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(WIN - 1)) begin
        load_d  = 1'b0;
        valid_d = 1'b1;
      end
    end else begin
      if (go_down) y_d = y_q + 1'b1;
      if (go_up)   y_d = y_q - 1'b1;
      if (go_lat)  x_d = x_q + 1'b1;
    end
  end

  assign upd = start | load_q | acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      cnt_q   <= '0;
      load_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (upd) begin
      x_q     <= x_d;
      y_q     <= y_d;
      cnt_q   <= cnt_d;
      load_q  <= load_d;
      valid_q <= valid_d;
    end
  end

  assign win_valid = valid_q;
  assign win_x     = x_q;
  assign win_y     = y_q;
endmodule

// File: rtl/swin_lanes.sv
module swin_lanes #(
  parameter int WIN   = 16,
  parameter int AREA  = 31,
  parameter int PIX_W = 8,
  parameter int AW    = $clog2(AREA)
) (
  input  logic [AW-1:0]         x,
  input  logic [AREA*PIX_W-1:0] lm_data,
  output logic [WIN*PIX_W-1:0]  row_bytes,
  output logic [PIX_W-1:0]      sh_byte,
  output logic [PIX_W-1:0]      nx_byte
);
  localparam int PADW  = (AREA + 2) * PIX_W;
  localparam int SLICE = (WIN + 2) * PIX_W;

  logic [PADW-1:0]  padded;
  logic [SLICE-1:0] lane_slice;

  // Two zero lanes on top keep the shadow and next-column lanes in range
  assign padded     = {{(2 * PIX_W){1'b0}}, lm_data};
  assign lane_slice = padded[int'(x) * PIX_W +: SLICE];
  assign row_bytes  = lane_slice[WIN*PIX_W-1:0];
  assign sh_byte    = lane_slice[WIN*PIX_W +: PIX_W];
  assign nx_byte    = lane_slice[(WIN+1)*PIX_W +: PIX_W];
endmodule

// File: rtl/swin_shadow.sv
module swin_shadow #(
  parameter int WIN   = 16,
  parameter int PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 fill_bot,
  input  logic                 fill_top,
  input  logic                 lat,
  input  logic                 lat_at_bottom,
  input  logic                 col_ok,
  input  logic                 next_ok,
  input  logic [PIX_W-1:0]     in_byte,
  input  logic [PIX_W-1:0]     nx_byte,
  output logic [WIN*PIX_W-1:0] col_out,
  output logic                 full
);
  logic [PIX_W-1:0] s_q [WIN];
  logic [PIX_W-1:0] s_d [WIN];
  logic [WIN-1:0]   v_q, v_d;
  logic             en;

  always_comb begin
    s_d = s_q;
    v_d = v_q;
    if (clear) begin
      for (int i = 0; i < WIN; i++) s_d[i] = '0;
      v_d = '0;
    end else if (fill_bot) begin
      for (int i = 0; i < WIN - 1; i++) s_d[i] = s_q[i+1];
      s_d[WIN-1] = in_byte;
      v_d        = {col_ok, v_q[WIN-1:1]};
    end else if (fill_top) begin
      for (int i = 1; i < WIN; i++) s_d[i] = s_q[i-1];
      s_d[0] = in_byte;
      v_d    = {v_q[WIN-2:0], col_ok};
    end else if (lat) begin
      v_d = '0;
      if (lat_at_bottom) begin
        s_d[0] = nx_byte;
        v_d[0] = next_ok;
      end else begin
        s_d[WIN-1] = nx_byte;
        v_d[WIN-1] = next_ok;
      end
    end
  end

  assign en = clear | fill_bot | fill_top | lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) s_q[i] <= '0;
      v_q <= '0;
    end else if (en) begin
      s_q <= s_d;
      v_q <= v_d;
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_col
    assign col_out[i*PIX_W +: PIX_W] = s_q[i];
  end

  assign full = &v_q;
endmodule

// File: rtl/swin_grid.sv
module swin_grid #(
  parameter int WIN   = 16,
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     fill_bot,
  input  logic                     fill_top,
  input  logic                     shift_left,
  input  logic [WIN*PIX_W-1:0]     new_row,
  input  logic [WIN*PIX_W-1:0]     new_col,
  output logic [WIN*WIN*PIX_W-1:0] pix
);
  logic [PIX_W-1:0] g_q [WIN][WIN];
  logic [PIX_W-1:0] g_d [WIN][WIN];
  logic             en;

  always_comb begin
    g_d = g_q;
    if (clear) begin
      for (int i = 0; i < WIN; i++)
        for (int j = 0; j < WIN; j++) g_d[i][j] = '0;
    end else if (fill_bot) begin
      for (int i = 0; i < WIN - 1; i++) g_d[i] = g_q[i+1];
      for (int j = 0; j < WIN; j++) g_d[WIN-1][j] = new_row[j*PIX_W +: PIX_W];
    end else if (fill_top) begin
      for (int i = 1; i < WIN; i++) g_d[i] = g_q[i-1];
      for (int j = 0; j < WIN; j++) g_d[0][j] = new_row[j*PIX_W +: PIX_W];
    end else if (shift_left) begin
      for (int i = 0; i < WIN; i++) begin
        for (int j = 0; j < WIN - 1; j++) g_d[i][j] = g_q[i][j+1];
        g_d[i][WIN-1] = new_col[i*PIX_W +: PIX_W];
      end
    end
  end

  assign en = clear | fill_bot | fill_top | shift_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++)
        for (int j = 0; j < WIN; j++) g_q[i][j] <= '0;
    end else if (en) begin
      g_q <= g_d;
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_row
    for (genvar j = 0; j < WIN; j++) begin : g_px
      assign pix[(i*WIN+j)*PIX_W +: PIX_W] = g_q[i][j];
    end
  end
endmodule

// File: rtl/swin_array.sv
module swin_array #(
  parameter int WIN   = 16,
  parameter int AREA  = 31,
  parameter int PIX_W = 8,
  parameter int AW    = $clog2(AREA)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [AW-1:0]            org_x,
  input  logic [AW-1:0]            org_y,
  input  logic                     step_valid,
  input  logic [1:0]               step_dir,
  output logic                     step_ready,
  output logic [AREA-1:0]          lm_en,
  output logic [AW-1:0]            lm_row,
  input  logic [AREA*PIX_W-1:0]    lm_data,
  output logic                     win_valid,
  output logic [AW-1:0]            win_x,
  output logic [AW-1:0]            win_y,
  output logic [WIN*WIN*PIX_W-1:0] win_pix
);
  logic                 sh_full;
  logic                 op_clear, op_fill_bot, op_fill_top, op_lat;
  logic                 lat_at_bottom, col_ok, next_ok;
  logic [WIN*PIX_W-1:0] row_bytes, sh_col;
  logic [PIX_W-1:0]     sh_byte, nx_byte;

  swin_ctrl #(.WIN(WIN), .AREA(AREA), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .step_valid(step_valid), .step_dir(step_dir), .sh_full(sh_full),
    .step_ready(step_ready), .win_valid(win_valid), .win_x(win_x), .win_y(win_y),
    .lm_en(lm_en), .lm_row(lm_row), .op_clear(op_clear), .op_fill_bot(op_fill_bot),
    .op_fill_top(op_fill_top), .op_lat(op_lat), .lat_at_bottom(lat_at_bottom),
    .col_ok(col_ok), .next_ok(next_ok)
  );

  swin_lanes #(.WIN(WIN), .AREA(AREA), .PIX_W(PIX_W), .AW(AW)) u_lanes (
    .x(win_x), .lm_data(lm_data), .row_bytes(row_bytes),
    .sh_byte(sh_byte), .nx_byte(nx_byte)
  );

  swin_shadow #(.WIN(WIN), .PIX_W(PIX_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .clear(op_clear), .fill_bot(op_fill_bot),
    .fill_top(op_fill_top), .lat(op_lat), .lat_at_bottom(lat_at_bottom),
    .col_ok(col_ok), .next_ok(next_ok), .in_byte(sh_byte), .nx_byte(nx_byte),
    .col_out(sh_col), .full(sh_full)
  );

  swin_grid #(.WIN(WIN), .PIX_W(PIX_W)) u_grid (
    .clk(clk), .rst_n(rst_n), .clear(op_clear), .fill_bot(op_fill_bot),
    .fill_top(op_fill_top), .shift_left(op_lat), .new_row(row_bytes),
    .new_col(sh_col), .pix(win_pix)
  );
endmodule

// File: rtl/swin_check.sv
module swin_check #(
  parameter int WIN   = 16,
  parameter int AREA  = 31,
  parameter int PIX_W = 8,
  parameter int AW    = $clog2(AREA)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     step_valid,
  input logic [1:0]               step_dir,
  input logic                     step_ready,
  input logic                     win_valid,
  input logic [AW-1:0]            win_x,
  input logic [AW-1:0]            win_y,
  input logic [WIN*WIN*PIX_W-1:0] win_pix,
  input logic [AREA-1:0]          lm_en,
  input logic                     sh_full
);
  localparam int MAXPOS = AREA - WIN;

  logic acc;
  assign acc = step_valid && step_ready;

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!win_valid && win_pix == '0));

  a_r4_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dir == 2'b11) |-> !step_ready);

  a_r5_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    step_ready |-> (win_valid && !start));

  a_r5_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(win_x) <= MAXPOS) && (int'(win_y) <= MAXPOS));

  a_r6_down_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_dir == 2'b00) |=>
      (int'(win_y) == int'($past(win_y)) + 1 && win_x == $past(win_x)));

  a_r6_up_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_dir == 2'b01) |=>
      (int'(win_y) == int'($past(win_y)) - 1 && win_x == $past(win_x)));

  a_r6_lat_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_dir == 2'b10) |=>
      (int'(win_x) == int'($past(win_x)) + 1 && win_y == $past(win_y)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !acc && !start) |=>
      ($stable(win_pix) && $stable(win_x) && $stable(win_y)));

  a_r8_port_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lm_en) <= WIN + 1);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !acc) |-> (lm_en == '0));

  a_r8_lat_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_dir == 2'b10) |-> $onehot0(lm_en));

  a_r9_lat_needs_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_dir == 2'b10) |-> sh_full);
endmodule

bind swin_array swin_check #(.WIN(WIN), .AREA(AREA), .PIX_W(PIX_W), .AW(AW)) u_check (
  .clk(clk), .rst_n(rst_n), .start(start), .step_valid(step_valid),
  .step_dir(step_dir), .step_ready(step_ready), .win_valid(win_valid),
  .win_x(win_x), .win_y(win_y), .win_pix(win_pix), .lm_en(lm_en),
  .sh_full(sh_full)
);

// File: tb/swin_array_test.sv
module swin_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int SA = 7;
  localparam int P  = 8;
  localparam int AW = $clog2(SA);
  localparam int MAXP = SA - W;

  logic              clk, rst_n, start, step_valid, step_ready, win_valid;
  logic [AW-1:0]     org_x, org_y, lm_row, win_x, win_y;
  logic [1:0]        step_dir;
  logic [SA-1:0]     lm_en;
  logic [SA*P-1:0]   lm_data;
  logic [W*W*P-1:0]  win_pix;

  int n_chk = 0;
  int n_fail = 0;
  int cx, cy;
  bit have [SA];
  logic [15:0] lfsr = 16'hACE1;

  swin_array #(.WIN(W), .AREA(SA), .PIX_W(P)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .step_valid(step_valid), .step_dir(step_dir), .step_ready(step_ready),
    .lm_en(lm_en), .lm_row(lm_row), .lm_data(lm_data), .win_valid(win_valid),
    .win_x(win_x), .win_y(win_y), .win_pix(win_pix)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pix(int r, int c);
    return 8'((r * 37 + c * 11 + 3) & 255);
  endfunction

  // Line-memory model: byte m is pixel (lm_row, m) when enabled, filler otherwise
  always_comb begin
    for (int m = 0; m < SA; m++)
      lm_data[m*P +: P] = lm_en[m] ? pix(int'(lm_row), m) : 8'hA5;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_win(string req);
    int bad_i = -1, bad_j = -1;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (bad_i < 0 && win_pix[(i*W+j)*P +: P] !== pix(cy + i, cx + j)) begin
          bad_i = i; bad_j = j;
        end
    if (bad_i < 0) chk(1'b1, req, "window", 0, 0);
    else chk(1'b0, req, $sformatf("window pixel (%0d,%0d)", bad_i, bad_j),
             int'(win_pix[(bad_i*W+bad_j)*P +: P]), int'(pix(cy + bad_i, cx + bad_j)));
    chk(int'(win_x) == cx && int'(win_y) == cy, req, "position x*16+y",
        int'(win_x) * 16 + int'(win_y), cx * 16 + cy);
  endtask

  function automatic bit shadow_full();
    for (int r = cy; r < cy + W; r++) if (!have[r]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic start_at(int ox, int oy);
    start = 1'b1; org_x = AW'(ox); org_y = AW'(oy);
    @(negedge clk);
    start = 1'b0;
    chk(win_valid == 1'b0 && win_pix == '0, "R2", "cleared after start", int'(win_valid), 0);
    repeat (W - 1) @(negedge clk);
    chk(win_valid == 1'b0, "R2", "valid before load done", int'(win_valid), 0);
    @(negedge clk);
    chk(win_valid == 1'b1, "R2", "valid after load", int'(win_valid), 1);
    cx = (ox > MAXP) ? MAXP : ox;
    cy = (oy > MAXP) ? MAXP : oy;
    for (int r = 0; r < SA; r++) have[r] = (cx + W < SA) && r >= cy && r < cy + W;
    check_win("R2");
  endtask

  // Returns whether the step was accepted
  task automatic step(int dir, output bit accepted);
    bit exp_rdy;
    logic [SA-1:0] exp_en;
    int exp_row;
    step_valid = 1'b1; step_dir = 2'(dir);
    #1;
    case (dir)
      0: exp_rdy = cy < MAXP;
      1: exp_rdy = cy > 0;
      2: exp_rdy = cx < MAXP && shadow_full();
      default: exp_rdy = 1'b0;
    endcase
    chk(step_ready == exp_rdy, (dir == 2) ? "R9" : (dir == 3) ? "R4" : "R5",
        $sformatf("ready dir %0d", dir), int'(step_ready), int'(exp_rdy));
    exp_en = '0;
    exp_row = 0;
    if (exp_rdy) begin
      for (int m = 0; m < SA; m++)
        exp_en[m] = (dir < 2) ? (m >= cx && m <= cx + W) : (m == cx + W + 1);
      exp_row = (dir == 0) ? cy + W : (dir == 1) ? cy - 1 : (cy == MAXP) ? cy : cy + W - 1;
    end
    chk(lm_en == exp_en, "R8", "enables", int'(lm_en), int'(exp_en));
    if (exp_rdy)
      chk(int'(lm_row) == exp_row, "R8", "row address", int'(lm_row), exp_row);
    @(posedge clk);
    @(negedge clk);
    step_valid = 1'b0;
    accepted = exp_rdy;
    if (exp_rdy) begin
      if (dir == 0) begin
        cy++;
        for (int r = 0; r < SA; r++) if (r < cy) have[r] = 1'b0;
        if (cx + W < SA) have[cy + W - 1] = 1'b1;
      end else if (dir == 1) begin
        cy--;
        for (int r = 0; r < SA; r++) if (r >= cy + W) have[r] = 1'b0;
        if (cx + W < SA) have[cy] = 1'b1;
      end else begin
        cx++;
        for (int r = 0; r < SA; r++) have[r] = 1'b0;
        if (cx + W < SA) have[(cy == MAXP) ? cy : cy + W - 1] = 1'b1;
      end
      check_win("R6");
    end else begin
      check_win("R7");
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      #1;
      chk(lm_en == '0, "R8", "idle enables", int'(lm_en), 0);
      @(negedge clk);
      check_win("R7");
    end
  endtask

  task automatic serpentine();
    bit acc;
    bit down = 1'b1;
    forever begin
      while (down ? cy < MAXP : cy > 0) step(down ? 0 : 1, acc);
      step(down ? 0 : 1, acc);
      chk(!acc, "R5", "step past edge", int'(acc), 0);
      if (cx >= MAXP) break;
      step(2, acc);
      chk(acc, "R10", "turnaround accepted at once", int'(acc), 1);
      down = !down;
    end
    step(2, acc);
    chk(!acc, "R5", "sideways past edge", int'(acc), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit acc;
    rst_n = 1'b0; start = 1'b0; org_x = '0; org_y = '0;
    step_valid = 1'b0; step_dir = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(win_valid == 1'b0 && step_ready == 1'b0, "R1", "valid/ready", int'(win_valid), 0);
    chk(win_x == '0 && win_y == '0 && lm_en == '0, "R1", "position/enables",
        int'(lm_en), 0);
    chk(win_pix == '0, "R1", "window zero", 0, 0);
    @(negedge clk);

    // R3 R10: full serpentine from every origin
    for (int ox = 0; ox <= MAXP; ox++)
      for (int oy = 0; oy <= MAXP; oy++) begin
        start_at(ox, oy);
        check_win("R3");
        idle(2);
        serpentine();
      end

    // R2: origin clamping
    start_at(6, 5);
    chk(int'(win_x) == MAXP && int'(win_y) == MAXP, "R2", "clamped origin",
        int'(win_x) * 16 + int'(win_y), MAXP * 16 + MAXP);

    // R9: back-to-back sideways steps; second must wait for refill
    start_at(0, 0);
    step(2, acc);
    chk(acc, "R9", "sideways after preload", int'(acc), 1);
    step(2, acc);
    chk(!acc, "R9", "sideways with partial shadow", int'(acc), 0);
    step(0, acc); step(0, acc);
    step(2, acc);
    chk(!acc, "R9", "sideways after two fills", int'(acc), 0);
    step(0, acc);
    step(2, acc);
    chk(acc, "R9", "sideways after full refill", int'(acc), 1);

    // R4: reserved code
    step(3, acc);
    chk(!acc, "R4", "reserved code", int'(acc), 0);

    // Pseudo-random walk with reversals, reserved codes and restarts
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:4] == 4'hF) begin
        start_at(int'(lfsr[10:8]), int'(lfsr[13:11]));
      end else if (lfsr[7:4] == 4'hE) begin
        idle(1);
      end else begin
        step(int'(lfsr[1:0]), acc);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule